// File: doc/BRIEF.md
# Dual-Channel Beat-Edge Deglitcher and Phase Timestamper

The block belongs to a dual-mixer time-difference measurement. Two reference clocks run at almost the same frequency. Each one is captured by a register clocked from a third, slightly offset clock. The captured bit is a slow square wave at the beat frequency. Around each beat transition, phase noise makes the captured bit flip back and forth for many samples. For each channel, the block cleans up this bitstream, finds each rising beat transition, and gives it a timestamp. The timestamp comes from a free-running counter on the offset clock. When both channels have a fresh timestamp, the block outputs the signed difference between them.

Each channel controls its estimator with a three-state machine. `ST_DISARMED` counts consecutive low samples and moves to `ST_ARMED` after `ARM_LOW` of them. Any high sample in `ST_DISARMED` restarts that count. `ST_ARMED` waits for the first high sample, then opens a transition window by moving to `ST_WINDOW`. `ST_WINDOW` counts the low samples that fall inside the window. When `STABLE_HI` consecutive high samples have been seen, it closes the window, reports the edge and returns to `ST_DISARMED`. Only rising transitions are reported. Noise on falling transitions is absorbed while the channel is disarmed. The reported position is the window start plus the number of low samples inside the window. This is the point where the counts of low and high samples balance. `STABLE_HI` must be at least 2 and `ARM_LOW` at least 1.

Top module: `ddmtd_core`

## Requirements
- R1: The input level present at the n-th rising clock edge after reset is released carries timestamp n mod 2^TS_W. The internal counter advances by exactly one each cycle.
- R2: Reset leaves both channels disarmed with all valid outputs low. An input that is high from reset onward produces no edge until a full low run has been seen.
- R3: A channel arms only after ARM_LOW consecutive low samples. A high sample before the run completes restarts the count, so ARM_LOW-1 lows followed by a high never arm the channel.
- R4: An armed channel opens its window at the first high sample. The window stays open through shorter runs of highs mixed with lows. It closes on the STABLE_HI-th consecutive high sample.
- R5: The reported edge timestamp equals the timestamp of the window-opening sample plus the count of low samples inside the window, mod 2^TS_W.
- R6: The per-channel valid is a single-cycle pulse. It is high in the cycle after the clock edge that follows the edge capturing the closing high sample.
- R7: After a window closes, further highs and any toggling on the falling transition produce no edge report until the channel has re-armed.
- R8: When both channels have a pending edge, the diff valid pulses for one cycle in the following cycle, and both pending flags clear. The diff value is the channel B timestamp minus the channel A timestamp, as a two's-complement TS_W-bit value. Edges from both channels in the same cycle pair with each other.
- R9: A second edge on one channel, arriving before the other channel reports, replaces the pending timestamp of that channel.
- R10: Timestamps and differences wrap modulo 2^TS_W, so a pair that straddles the counter wrap yields the correct signed difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Offset sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a_i | input | 1 | Reference clock A, sampled |
| ref_b_i | input | 1 | Reference clock B, sampled |
| edge_valid_a_o | output | 1 | Channel A rising-edge pulse |
| edge_ts_a_o | output | TS_W | Channel A edge timestamp |
| edge_valid_b_o | output | 1 | Channel B rising-edge pulse |
| edge_ts_b_o | output | TS_W | Channel B edge timestamp |
| diff_valid_o | output | 1 | Difference pulse |
| diff_o | output | TS_W | Signed B minus A |

## Verification
A wrong arm count, or a window that closes too early, shows up on the next rising transition. The edge is then missed, reported a cycle off, or reported with a timestamp that is off by the number of low samples inside the window. A stuck state machine shows up as a missing pulse within one beat period. A pending-flag error in the pairing stage appears at the next diff pulse, which arrives late, twice, or with a stale partner timestamp. Counter faults show up in every timestamp, including the pair that straddles the wrap.

// File: rtl/ddmtd_pkg.sv
package ddmtd_pkg;
    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_WINDOW   = 2'd2
    } chan_state_t;
endpackage

// File: rtl/ddmtd_beat_chan.sv
module ddmtd_beat_chan
    import ddmtd_pkg::*;
#(
    parameter int TS_W      = 32,
    parameter int ARM_LOW   = 64,
    parameter int STABLE_HI = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw_i,
    input  logic [TS_W-1:0] now_i,
    output logic            samp_o,
    output logic            edge_valid_o,
    output logic [TS_W-1:0] edge_ts_o
);
    localparam int LOW_W = $clog2(ARM_LOW + 1);
    localparam int HI_W  = $clog2(STABLE_HI + 1);
    localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(ARM_LOW - 1);
    localparam logic [HI_W-1:0]  HI_LAST  = HI_W'(STABLE_HI - 1);

    chan_state_t     state, nxt;
    logic            samp_q;
    logic [LOW_W-1:0] low_cnt;
    logic [HI_W-1:0]  hi_cnt;
    logic [TS_W-1:0]  zero_cnt;
    logic [TS_W-1:0]  win_start;

    // sampling register on the offset clock
    always_ff @(posedge clk) begin
        if (rst) samp_q <= 1'b0;
        else     samp_q <= raw_i;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_DISARMED: if (!samp_q && low_cnt == LOW_LAST) nxt = ST_ARMED;
            ST_ARMED:    if (samp_q) nxt = ST_WINDOW;
            ST_WINDOW:   if (samp_q && hi_cnt == HI_LAST) nxt = ST_DISARMED;
            default:     nxt = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_DISARMED;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt      <= '0;
            hi_cnt       <= '0;
            zero_cnt     <= '0;
            win_start    <= '0;
            edge_valid_o <= 1'b0;
            edge_ts_o    <= '0;
        end else begin
            edge_valid_o <= 1'b0;
            unique case (state)
                ST_DISARMED: low_cnt <= samp_q ? '0 : low_cnt + 1'b1;
                ST_ARMED: begin
                    if (samp_q) begin
                        win_start <= now_i;
                        zero_cnt  <= '0;
                        hi_cnt    <= HI_W'(1);
                    end
                end
                ST_WINDOW: begin
                    if (samp_q) begin
                        if (hi_cnt == HI_LAST) begin
                            edge_valid_o <= 1'b1;
                            edge_ts_o    <= win_start + zero_cnt;
                            low_cnt      <= '0;
                        end else begin
                            hi_cnt <= hi_cnt + 1'b1;
                        end
                    end else begin
                        zero_cnt <= zero_cnt + 1'b1;
                        hi_cnt   <= '0;
                    end
                end
                default: low_cnt <= '0;
            endcase
        end
    end

    assign samp_o = samp_q;
endmodule

// File: rtl/ddmtd_phase_diff.sv
module ddmtd_phase_diff #(
    parameter int TS_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   va_i,
    input  logic [TS_W-1:0]        tsa_i,
    input  logic                   vb_i,
    input  logic [TS_W-1:0]        tsb_i,
    output logic                   diff_valid_o,
    output logic signed [TS_W-1:0] diff_o
);
    logic            pend_a, pend_b;
    logic [TS_W-1:0] held_a, held_b;
    logic            pa_n, pb_n;
    logic [TS_W-1:0] ta_n, tb_n;

    always_comb begin
        pa_n = pend_a | va_i;
        pb_n = pend_b | vb_i;
        ta_n = va_i ? tsa_i : held_a;
        tb_n = vb_i ? tsb_i : held_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_a       <= 1'b0;
            pend_b       <= 1'b0;
            held_a       <= '0;
            held_b       <= '0;
            diff_valid_o <= 1'b0;
            diff_o       <= '0;
        end else begin
            diff_valid_o <= 1'b0;
            held_a       <= ta_n;
            held_b       <= tb_n;
            if (pa_n && pb_n) begin
                diff_valid_o <= 1'b1;
                diff_o       <= $signed(tb_n - ta_n);
                pend_a       <= 1'b0;
                pend_b       <= 1'b0;
            end else begin
                pend_a <= pa_n;
                pend_b <= pb_n;
            end
        end
    end
endmodule

// File: rtl/ddmtd_core.sv
module ddmtd_core #(
    parameter int TS_W      = 32,
    parameter int ARM_LOW   = 64,
    parameter int STABLE_HI = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ref_a_i,
    input  logic                   ref_b_i,
    output logic                   edge_valid_a_o,
    output logic [TS_W-1:0]        edge_ts_a_o,
    output logic                   edge_valid_b_o,
    output logic [TS_W-1:0]        edge_ts_b_o,
    output logic                   diff_valid_o,
    output logic signed [TS_W-1:0] diff_o
);
    localparam int NCH = 2;

    logic [TS_W-1:0] tbase;
    logic [NCH-1:0]  raw;
    logic [NCH-1:0]  samp;
    logic [NCH-1:0]  ev;
    logic [TS_W-1:0] ets [NCH];

    assign raw = {ref_b_i, ref_a_i};

    always_ff @(posedge clk) begin
        if (rst) tbase <= '0;
        else     tbase <= tbase + 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ddmtd_beat_chan #(
            .TS_W(TS_W), .ARM_LOW(ARM_LOW), .STABLE_HI(STABLE_HI)
        ) u_chan (
            .clk(clk), .rst(rst), .raw_i(raw[g]), .now_i(tbase),
            .samp_o(samp[g]), .edge_valid_o(ev[g]), .edge_ts_o(ets[g])
        );
    end

    ddmtd_phase_diff #(.TS_W(TS_W)) u_diff (
        .clk(clk), .rst(rst),
        .va_i(ev[0]), .tsa_i(ets[0]),
        .vb_i(ev[1]), .tsb_i(ets[1]),
        .diff_valid_o(diff_valid_o), .diff_o(diff_o)
    );

    assign edge_valid_a_o = ev[0];
    assign edge_ts_a_o    = ets[0];
    assign edge_valid_b_o = ev[1];
    assign edge_ts_b_o    = ets[1];
endmodule

// File: rtl/ddmtd_chk.sv
module ddmtd_chk #(
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [TS_W-1:0] tbase,
    input logic [1:0]      samp,
    input logic [1:0]      ev,
    input logic            dv
);
    // R1
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tbase == $past(tbase) + 1'b1);

    for (genvar g = 0; g < 2; g++) begin : g_c
        // R6
        pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
            ev[g] |=> !ev[g]);
        // R4
        closes_high_chk: assert property (@(posedge clk) disable iff (rst)
            ev[g] |-> $past(samp[g]) && $past(samp[g], 2));
    end

    // R8
    diff_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dv |=> !dv);
    // R8
    diff_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
        dv |-> $past(ev[0] || ev[1]));
endmodule

bind ddmtd_core ddmtd_chk #(.TS_W(TS_W)) u_chk (
    .clk(clk), .rst(rst), .tbase(tbase), .samp(samp),
    .ev({edge_valid_b_o, edge_valid_a_o}), .dv(diff_valid_o)
);

// File: tb/tb_ddmtd_core.sv
module tb_ddmtd_core;
    localparam int TSW = 12;
    localparam int ARM = 8;
    localparam int SHI = 4;
    localparam int LEN = 4400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_a = 1'b0, ref_b = 1'b0;
    logic eva, evb, dv;
    logic [TSW-1:0] tsa, tsb;
    logic signed [TSW-1:0] diff;

    always #4 clk = ~clk;

    ddmtd_core #(.TS_W(TSW), .ARM_LOW(ARM), .STABLE_HI(SHI)) dut (
        .clk(clk), .rst(rst), .ref_a_i(ref_a), .ref_b_i(ref_b),
        .edge_valid_a_o(eva), .edge_ts_a_o(tsa),
        .edge_valid_b_o(evb), .edge_ts_b_o(tsb),
        .diff_valid_o(dv), .diff_o(diff)
    );

    bit stim [2][LEN+1];
    int pos [2];
    logic [TSW-1:0] q_ts [2][$];
    int             q_cy [2][$];
    int tests = 0, fails = 0;
    int cyc = 0;
    bit running = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic app(input int ch, input bit v, input int n);
        for (int i = 0; i < n; i++) begin
            stim[ch][pos[ch]] = v;
            pos[ch]++;
        end
    endtask

    task automatic pad(input int ch, input int upto);
        while (pos[ch] < upto) app(ch, 1'b0, 1);
    endtask

    // driver: low run, noise (LSB first, starts with 1, ends with 0), stable highs
    task automatic edge_seq(input int ch, input int low, input logic [15:0] nz, input int nl);
        int start, zeros;
        app(ch, 1'b0, low);
        start = pos[ch];
        zeros = 0;
        for (int i = 0; i < nl; i++) begin
            app(ch, nz[i], 1);
            if (!nz[i]) zeros++;
        end
        app(ch, 1'b1, SHI);
        q_ts[ch].push_back(TSW'(start + zeros));   // R5, R1
        q_cy[ch].push_back(pos[ch]);               // R6: last high index + 1
    endtask

    // monitor / scoreboard
    logic [TSW-1:0] last_ts [2];
    bit pend [2] = '{0, 0};
    bit prev_ev [2] = '{0, 0};
    bit dpend = 0;
    logic [TSW-1:0] dexp;

    always @(posedge clk) if (running) cyc <= cyc + 1;

    always @(negedge clk) if (running && !done) begin
        bit evs [2];
        logic [TSW-1:0] tss [2];
        evs[0] = eva; evs[1] = evb; tss[0] = tsa; tss[1] = tsb;
        if (dpend) begin
            chk(dv === 1'b1, "R8 diff valid", int'(dv), 1);
            chk(diff === dexp, "R8 R9 R10 diff value", int'(diff), int'($signed(dexp)));
            dpend = 0;
        end else if (dv !== 1'b0) begin
            chk(0, "R8 unexpected diff", int'(dv), 0);
        end
        for (int c = 0; c < 2; c++) begin
            if (evs[c]) begin
                if (prev_ev[c]) chk(0, "R6 pulse longer than one cycle", 1, 0);
                if (q_ts[c].size() == 0) begin
                    chk(0, "R2 R3 R7 unexpected edge", int'(tss[c]), -1);
                end else begin
                    logic [TSW-1:0] et;
                    int ec;
                    et = q_ts[c].pop_front();
                    ec = q_cy[c].pop_front();
                    chk(tss[c] === et, "R5 R1 edge timestamp", int'(tss[c]), int'(et));
                    chk(cyc == ec, "R6 edge cycle", cyc, ec);
                    last_ts[c] = et;
                    pend[c] = 1;
                end
            end
            prev_ev[c] = evs[c];
        end
        if (pend[0] && pend[1]) begin
            dexp = last_ts[1] - last_ts[0];
            dpend = 1;
            pend[0] = 0;
            pend[1] = 0;
        end
    end

    initial begin
        pos[0] = 1; pos[1] = 1;
        // channel A: high from reset (R2), then three edges before B's first (R9)
        app(0, 1'b1, 5);
        edge_seq(0, 10, 16'b01, 2);
        app(0, 1'b0, 7); app(0, 1'b1, 1); app(0, 1'b0, 7); app(0, 1'b1, 6); // R3: never armed
        edge_seq(0, 8, 16'b0101_1011, 8);       // R3 exact run, R4 noise
        app(0, 1'b1, 3);
        app(0, 1'b1, 1); app(0, 1'b0, 1); app(0, 1'b1, 1); app(0, 1'b0, 2); app(0, 1'b1, 1); // R7
        edge_seq(0, 20, 16'b0111_0001, 8);
        // channel B first edge, late
        edge_seq(1, 300, 16'b0010_1101, 8);
        // simultaneous close on both channels (R8)
        pad(0, 600); pad(1, 600);
        edge_seq(0, 10, 16'b0010_1101, 8);
        edge_seq(1, 10, 16'b0000_0011, 8);
        // B leads A by a wide margin
        pad(0, 1000); pad(1, 1000);
        edge_seq(1, 10, 16'b0110_0101, 8);
        edge_seq(0, 500, 16'b01, 2);
        // straddle the counter wrap (R10)
        pad(0, 4070); pad(1, 4070);
        edge_seq(1, 10, 16'b0101_1011, 8);
        edge_seq(0, 40, 16'b0000_0101, 8);
        pad(0, LEN + 1); pad(1, LEN + 1);

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(eva === 1'b0 && evb === 1'b0 && dv === 1'b0, "R2 reset outputs", int'({eva, evb, dv}), 0);
        rst = 1'b0;
        running = 1;
        for (int n = 1; n <= LEN; n++) begin
            ref_a = stim[0][n];
            ref_b = stim[1][n];
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        done = 1;
        chk(q_ts[0].size() == 0, "R4 channel A edges missing", q_ts[0].size(), 0);
        chk(q_ts[1].size() == 0, "R4 channel B edges missing", q_ts[1].size(), 0);
        chk(!dpend, "R8 diff missing", int'(dpend), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (LEN + 500) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule